// File: doc/BRIEF.md
# Zero-Address Stack Expression Engine

This block executes stack-style instructions one at a time. It holds an operand stack and a small word-addressed data memory. Only the two data-movement instructions carry an address. A load instruction copies a memory word onto the stack. A store instruction writes the top entry back to memory and removes it. The add and multiply instructions name no operand. Each one takes the two topmost entries, removes them and leaves a single result. A whole expression such as X = (A+B)*(C+D) therefore needs memory addresses only for its loads and its final store.

Instructions arrive on a valid/ready handshake. Each accepted instruction keeps the block busy for a fixed number of cycles. All state changes happen at the end of that busy window. The stack must hold enough entries for an instruction, and a load must find room. If either test fails, the instruction changes nothing and a sticky error flag is set instead. The data memory comes out of reset with a computed pattern, so expressions have known operands without any load port.

Top module: `zstack_engine`

## Requirements
- R1: After reset, `instr_ready` is 1, `stack_level` is 0, `err_flag` is 0 and `top_value` is 0. Memory word i holds MEM_INIT_BASE + i*MEM_INIT_STEP (2 + 3i by default).
- R2: An instruction is accepted on a rising edge where `instr_valid` and `instr_ready` are both 1. `instr_ready` then stays 0 for exactly EXEC_CYCLES cycles (default 2). Results are visible once it returns to 1.
- R3: Opcode 2'b00 (load) pushes the memory word at `instr_addr` onto the stack. `stack_level` rises by one and `top_value` shows that word.
- R4: Opcode 2'b01 (store) writes `top_value` into memory word `instr_addr` and lowers `stack_level` by one.
- R5: Opcode 2'b10 (add) replaces the two topmost entries with their sum modulo 2^16 and lowers `stack_level` by one.
- R6: Opcode 2'b11 (multiply) replaces the two topmost entries with the low 16 bits of their product and lowers `stack_level` by one.
- R7: The sequence load A, load B, add, load C, load D, add, multiply, store X leaves (A+B)*(C+D) in word X and an empty stack.
- R8: A load when `stack_level` equals STACK_DEPTH (8) sets `err_flag`. The stack is left unchanged.
- R9: A store with an empty stack, or an add or multiply with fewer than two entries, sets `err_flag`. The stack and the memory are left unchanged.
- R10: `err_flag` stays 1 until reset. Instructions that follow it still execute normally.
- R11: Add and multiply ignore `instr_addr`. No memory word changes for them.
- R12: While `instr_valid` is 0, changes on `instr_op` and `instr_addr` have no effect on the stack, the memory or `instr_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Block idle and able to accept an instruction |
| instr_op | input | 2 | Opcode: 00 load, 01 store, 10 add, 11 multiply |
| instr_addr | input | 4 | Memory word for load and store |
| top_value | output | 16 | Top stack entry, 0 when the stack is empty |
| stack_level | output | 4 | Number of entries on the stack |
| err_flag | output | 1 | Sticky overflow/underflow indication |

## Verification
The assertions check several rules on every cycle. The block goes busy after each accept. The level never exceeds the depth. The error flag is sticky. A fault leaves the level unchanged and raises the flag. A completed load raises the level by one, and a completed add or multiply lowers it by one. Nothing changes the level outside an execution. Only the bench scenarios can show data values. These include the memory pattern after reset, the value that a store writes and a later load reads back, the wraparound of sums and products, the full expression result, and the fact that faulting stores and ignored address fields leave memory untouched.

// File: rtl/zse_pkg.sv
package zse_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_ADD   = 2'b10,
      OP_MUL   = 2'b11
   } zse_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } zse_state_e;
endpackage

// File: rtl/zse_alu.sv
module zse_alu #(
   parameter int DATA_W   = 16,
   parameter int MUL_IMPL = 0   // 0: operator, 1: shift-add array
) (
   input  zse_pkg::zse_op_e    op,
   input  logic [DATA_W-1:0]   lhs,
   input  logic [DATA_W-1:0]   rhs,
   output logic [DATA_W-1:0]   result
);
   logic [DATA_W-1:0] prod;

   generate
      if (MUL_IMPL == 0) begin : g_mul_op
         assign prod = lhs * rhs;
      end else begin : g_mul_shift
         always_comb begin
            prod = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (rhs[i]) prod = prod + (lhs << i);
            end
         end
      end
   endgenerate

   assign result = (op == zse_pkg::OP_ADD) ? lhs + rhs : prod;
endmodule

// File: rtl/zse_operand_stack.sv
module zse_operand_stack #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_en,
   input  logic              pop_en,
   input  logic              merge_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] top,
   output logic [DATA_W-1:0] below,
   output logic [LVL_W-1:0]  level
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DATA_W-1:0] slots [DEPTH];
   logic [LVL_W-1:0]  idx_top;
   logic [LVL_W-1:0]  idx_below;

   assign idx_top   = level - LVL_W'(1);
   assign idx_below = level - LVL_W'(2);

   assign top   = (level != '0) ? slots[idx_top[PTR_W-1:0]] : '0;
   assign below = (level >= LVL_W'(2)) ? slots[idx_below[PTR_W-1:0]] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
         for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      end else if (push_en) begin
         slots[level[PTR_W-1:0]] <= wr_data;
         level <= level + LVL_W'(1);
      end else if (merge_en) begin
         slots[idx_below[PTR_W-1:0]] <= wr_data;
         level <= level - LVL_W'(1);
      end else if (pop_en) begin
         level <= level - LVL_W'(1);
      end
   end
endmodule

// File: rtl/zse_data_mem.sv
module zse_data_mem #(
   parameter int DATA_W    = 16,
   parameter int WORDS     = 16,
   parameter int INIT_BASE = 2,
   parameter int INIT_STEP = 3,
   localparam int ADDR_W   = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [WORDS];

   assign rd_data = words[addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) words[i] <= DATA_W'(INIT_BASE + i * INIT_STEP);
      end else if (wr_en) begin
         words[addr] <= wr_data;
      end
   end
endmodule

// File: rtl/zstack_engine.sv
module zstack_engine #(
   parameter int DATA_W        = 16,
   parameter int STACK_DEPTH   = 8,
   parameter int MEM_WORDS     = 16,
   parameter int EXEC_CYCLES   = 2,
   parameter int MUL_IMPL      = 0,
   parameter int MEM_INIT_BASE = 2,
   parameter int MEM_INIT_STEP = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             instr_valid,
   output logic                             instr_ready,
   input  logic [1:0]                       instr_op,
   input  logic [$clog2(MEM_WORDS)-1:0]     instr_addr,
   output logic [DATA_W-1:0]                top_value,
   output logic [$clog2(STACK_DEPTH+1)-1:0] stack_level,
   output logic                             err_flag
);
   import zse_pkg::*;

   localparam int ADDR_W = $clog2(MEM_WORDS);
   localparam int LVL_W  = $clog2(STACK_DEPTH + 1);
   localparam int CNT_W  = $clog2(EXEC_CYCLES + 1);

   generate
      if (STACK_DEPTH < 2) begin : g_bad_depth
         $error("STACK_DEPTH must be at least 2");
      end
      if (EXEC_CYCLES < 1) begin : g_bad_exec
         $error("EXEC_CYCLES must be at least 1");
      end
      if ((1 << ADDR_W) != MEM_WORDS) begin : g_bad_words
         $error("MEM_WORDS must be a power of two");
      end
      if (MUL_IMPL < 0 || MUL_IMPL > 1) begin : g_bad_mul
         $error("MUL_IMPL must be 0 or 1");
      end
   endgenerate

   zse_state_e        state;
   logic [CNT_W-1:0]  cnt;
   zse_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;
   logic              fire;
   logic              fault;
   logic              commit;

   logic [DATA_W-1:0] stk_top, stk_below, alu_y, mem_rd, stk_wr;
   logic [LVL_W-1:0]  level;

   assign accept = instr_valid && (state == ST_IDLE);
   assign fire   = (state == ST_BUSY) && (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         op_q   <= OP_LOAD;
         addr_q <= '0;
      end else if (accept) begin
         state  <= ST_BUSY;
         cnt    <= CNT_W'(EXEC_CYCLES);
         op_q   <= zse_op_e'(instr_op);
         addr_q <= instr_addr;
      end else if (state == ST_BUSY) begin
         cnt <= cnt - CNT_W'(1);
         if (fire) state <= ST_IDLE;
      end
   end

   always_comb begin
      unique case (op_q)
         OP_LOAD:  fault = (level == LVL_W'(STACK_DEPTH));
         OP_STORE: fault = (level == '0);
         default:  fault = (level < LVL_W'(2));
      endcase
   end

   assign commit = fire && !fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_flag <= 1'b0;
      else if (fire && fault) err_flag <= 1'b1;
   end

   assign stk_wr = (op_q == OP_LOAD) ? mem_rd : alu_y;

   zse_alu #(.DATA_W(DATA_W), .MUL_IMPL(MUL_IMPL)) u_alu (
      .op     (op_q),
      .lhs    (stk_below),
      .rhs    (stk_top),
      .result (alu_y)
   );

   zse_operand_stack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (commit && (op_q == OP_LOAD)),
      .pop_en   (commit && (op_q == OP_STORE)),
      .merge_en (commit && ((op_q == OP_ADD) || (op_q == OP_MUL))),
      .wr_data  (stk_wr),
      .top      (stk_top),
      .below    (stk_below),
      .level    (level)
   );

   zse_data_mem #(
      .DATA_W(DATA_W), .WORDS(MEM_WORDS),
      .INIT_BASE(MEM_INIT_BASE), .INIT_STEP(MEM_INIT_STEP)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit && (op_q == OP_STORE)),
      .addr    (addr_q),
      .wr_data (stk_top),
      .rd_data (mem_rd)
   );

   assign instr_ready = (state == ST_IDLE);
   assign top_value   = stk_top;
   assign stack_level = level;
endmodule

// File: rtl/zse_checker.sv
module zse_checker #(
   parameter int DEPTH = 8,
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             instr_valid,
   input logic             instr_ready,
   input logic [LVL_W-1:0] stack_level,
   input logic             err_flag,
   input logic             fire,
   input logic             fault,
   input logic [1:0]       op_q
);
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready) |=> !instr_ready);  // R2
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      stack_level <= LVL_W'(DEPTH));  // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);  // R10
   AST_FAULT_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && fault) |=> $stable(stack_level));  // R9
   AST_FAULT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && fault) |=> err_flag);  // R9
   AST_LOAD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !fault && op_q == 2'b00) |=> stack_level == $past(stack_level) + LVL_W'(1));  // R3
   AST_STORE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !fault && op_q == 2'b01) |=> stack_level == $past(stack_level) - LVL_W'(1));  // R4
   AST_MERGE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !fault && op_q[1]) |=> stack_level == $past(stack_level) - LVL_W'(1));  // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(stack_level));  // R12
endmodule

bind zstack_engine zse_checker #(
   .DEPTH(STACK_DEPTH), .LVL_W($clog2(STACK_DEPTH + 1))
) u_zse_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_ready (instr_ready),
   .stack_level (stack_level),
   .err_flag    (err_flag),
   .fire        (fire),
   .fault       (fault),
   .op_q        (op_q)
);

// File: tb/zstack_engine_bench.sv
module zstack_engine_bench;
   localparam int EXEC = 2;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic        instr_ready;
   logic [1:0]  instr_op = 2'b00;
   logic [3:0]  instr_addr = 4'd0;
   logic [15:0] top_value;
   logic [3:0]  stack_level;
   logic        err_flag;

   int total = 0;
   int failed = 0;

   logic [15:0] m_mem [16];
   logic [15:0] m_stk [DEPTH];
   int          m_lvl;
   bit          m_err;

   always #2 clk = ~clk;

   zstack_engine #(.EXEC_CYCLES(EXEC)) u_zstack_engine (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
      .instr_op(instr_op), .instr_addr(instr_addr), .top_value(top_value),
      .stack_level(stack_level), .err_flag(err_flag)
   );

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int m_top();
      return (m_lvl > 0) ? int'(m_stk[m_lvl-1]) : 0;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      instr_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) m_mem[i] = 16'(2 + 3 * i);
      m_lvl = 0;
      m_err = 1'b0;
      @(negedge clk);
   endtask

   // Issue one instruction, update the model, check busy time and visible state.
   task automatic run(logic [1:0] op, logic [3:0] addr, string tag);
      int busy;
      while (!instr_ready) @(negedge clk);
      instr_valid = 1'b1;
      instr_op = op;
      instr_addr = addr;
      @(negedge clk);
      instr_valid = 1'b0;
      busy = 0;
      while (!instr_ready && busy < 50) begin
         busy++;
         @(negedge clk);
      end
      check({tag, " R2 busy"}, busy, EXEC);
      case (op)
         2'b00: if (m_lvl == DEPTH) m_err = 1; else begin m_stk[m_lvl] = m_mem[addr]; m_lvl++; end
         2'b01: if (m_lvl == 0) m_err = 1; else begin m_mem[addr] = m_stk[m_lvl-1]; m_lvl--; end
         2'b10: if (m_lvl < 2) m_err = 1; else begin m_stk[m_lvl-2] = m_stk[m_lvl-2] + m_stk[m_lvl-1]; m_lvl--; end
         default: if (m_lvl < 2) m_err = 1; else begin m_stk[m_lvl-2] = m_stk[m_lvl-2] * m_stk[m_lvl-1]; m_lvl--; end
      endcase
      check({tag, " top"}, int'(top_value), m_top());
      check({tag, " level"}, int'(stack_level), m_lvl);
      check({tag, " err"}, int'(err_flag), int'(m_err));
   endtask

   task automatic t_reset_state();
      check("R1 ready", int'(instr_ready), 1);
      check("R1 level", int'(stack_level), 0);
      check("R1 err", int'(err_flag), 0);
      check("R1 top", int'(top_value), 0);
      run(2'b00, 4'd0, "R3 load w0");
      check("R1 word0", int'(top_value), 2);
      run(2'b00, 4'd15, "R3 load w15");
      check("R1 word15", int'(top_value), 47);
      run(2'b01, 4'd15, "R4 store");
      run(2'b01, 4'd0, "R4 store");
   endtask

   task automatic t_expression();
      run(2'b00, 4'd0, "R7 A");
      run(2'b00, 4'd1, "R7 B");
      run(2'b10, 4'd0, "R7 add");
      run(2'b00, 4'd2, "R7 C");
      run(2'b00, 4'd3, "R7 D");
      run(2'b10, 4'd0, "R7 add");
      run(2'b11, 4'd0, "R7 mul");
      run(2'b01, 4'd9, "R7 store X");
      check("R7 empty", int'(stack_level), 0);
      run(2'b00, 4'd9, "R7 reload X");
      check("R7 X value", int'(top_value), 133);
      run(2'b01, 4'd9, "R7 restore");
   endtask

   task automatic t_store_reload();
      run(2'b00, 4'd4, "R4 load");
      run(2'b00, 4'd6, "R4 load");
      run(2'b01, 4'd12, "R4 store w12");
      run(2'b00, 4'd12, "R4 reload");
      check("R4 w12 value", int'(top_value), 20);
      run(2'b10, 4'd0, "R5 add");
      check("R5 sum", int'(top_value), 34);
      run(2'b01, 4'd11, "R4 store");
   endtask

   task automatic t_wrap();
      run(2'b00, 4'd15, "R6 load");
      run(2'b00, 4'd15, "R6 load");
      run(2'b11, 4'd0, "R6 mul");
      check("R6 2209", int'(top_value), 2209);
      run(2'b01, 4'd13, "R6 store");
      run(2'b00, 4'd13, "R6 load");
      run(2'b00, 4'd13, "R6 load");
      run(2'b11, 4'd0, "R6 mul");
      check("R6 truncated", int'(top_value), 30017);
      run(2'b01, 4'd14, "R5 store");
      run(2'b00, 4'd14, "R5 load");
      run(2'b00, 4'd14, "R5 load");
      run(2'b10, 4'd0, "R5 add");
      run(2'b01, 4'd14, "R5 store");
      run(2'b00, 4'd14, "R5 load");
      run(2'b00, 4'd14, "R5 load");
      run(2'b10, 4'd0, "R5 add");
      check("R5 wrapped", int'(top_value), 54532);
      run(2'b01, 4'd10, "R5 store");
   endtask

   task automatic t_addr_ignored();
      run(2'b00, 4'd1, "R11 load");
      run(2'b00, 4'd2, "R11 load");
      run(2'b10, 4'd7, "R11 add addr7");
      run(2'b00, 4'd3, "R11 load");
      run(2'b11, 4'd8, "R11 mul addr8");
      run(2'b00, 4'd7, "R11 w7 kept");
      check("R11 w7", int'(top_value), 23);
      run(2'b00, 4'd8, "R11 w8 kept");
      check("R11 w8", int'(top_value), 26);
      run(2'b01, 4'd5, "R11 store");
      run(2'b01, 4'd5, "R11 store");
   endtask

   task automatic t_idle();
      int lvl0;
      int top0;
      lvl0 = int'(stack_level);
      top0 = int'(top_value);
      for (int i = 0; i < 10; i++) begin
         instr_op = 2'(i);
         instr_addr = 4'(i * 5);
         @(negedge clk);
      end
      check("R12 ready", int'(instr_ready), 1);
      check("R12 level", int'(stack_level), lvl0);
      check("R12 top", int'(top_value), top0);
   endtask

   task automatic t_overflow();
      do_reset();
      while (m_lvl < DEPTH) run(2'b00, 4'(m_lvl), "R3 fill");
      check("R8 full", int'(stack_level), DEPTH);
      run(2'b00, 4'd15, "R8 overflow");
      check("R8 err", int'(err_flag), 1);
      check("R8 top kept", int'(top_value), 23);
      run(2'b10, 4'd0, "R10 add after err");
      check("R10 sum", int'(top_value), 43);
      check("R10 err sticky", int'(err_flag), 1);
   endtask

   task automatic t_underflow();
      do_reset();
      run(2'b01, 4'd0, "R9 store empty");
      check("R9 err", int'(err_flag), 1);
      run(2'b00, 4'd0, "R9 w0 kept");
      check("R9 w0", int'(top_value), 2);
      run(2'b10, 4'd0, "R9 add one");
      run(2'b11, 4'd0, "R9 mul one");
      check("R9 level", int'(stack_level), 1);
      check("R9 top", int'(top_value), 2);
      run(2'b01, 4'd4, "R10 store after err");
      run(2'b00, 4'd4, "R10 reload");
      check("R10 w4", int'(top_value), 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failed++;
      total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      do_reset();
      t_reset_state();
      t_expression();
      t_store_reload();
      t_wrap();
      t_addr_ignored();
      run(2'b00, 4'd6, "R12 setup");
      t_idle();
      t_overflow();
      t_underflow();
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule